// File: doc/BRIEF.md
# Dual-Bus Flash Command Snoop Controller

This block sits on the transmit path of a serial flash controller that drives two byte-wide SPI buses. Each bus has its own flash device attached. At the start of a chip-select window it looks at the first byte sent, which is the flash instruction. From that opcode it works out how many address and dummy bytes follow. Those bytes must reach both devices unchanged, so each one is taken once from the transmit FIFO and sent on both buses. When the countdown runs out, the block starts striping: each bus takes its own byte from the FIFO, and each bus's received byte goes into the receive FIFO, bus 0 first. An opcode the block does not recognise leaves it in duplicate mode until chip select drops.

Every cycle in which `slot_vld` is high is one byte slot. In that cycle the block decides, from its state and the FIFO levels it is given, how many bytes to pop, what each bus sends, and which received bytes to push. It also flags transmit underflow and receive overflow. The snoop state is held in a register and changes only when a slot completes or when chip select is idle. All per-slot outputs are combinational from that state and the current inputs.

Top module: `flash_snoop_top`

## Requirements
- R1: After reset, or after a reset in the middle of operation, the state reads CHECK (`snoop_kind`=0) with `snoop_cnt`=0.
- R2: When `cs_idle` is high at a clock edge, the state becomes CHECK on that edge, even if a slot completes in the same cycle.
- R3: In CHECK, a completed slot whose `tx_head` is 0x03, 0x02, 0xA2 or 0x32 moves the state to COUNT (`snoop_kind`=1) with `snoop_cnt`=3.
- R4: In CHECK, a completed slot whose `tx_head` is 0x0B, 0x3B, 0x6B or 0xBB moves the state to COUNT with `snoop_cnt`=4.
- R5: In CHECK, opcode 0xEB loads COUNT with `snoop_cnt`=6. Any other opcode moves the state to NONE (`snoop_kind`=2).
- R6: In COUNT, each completed slot lowers `snoop_cnt` by one. A completed slot at `snoop_cnt`=1 moves the state to STRIPE (`snoop_kind`=3, `snoop_cnt`=0). A slot with `slot_vld` low changes nothing.
- R7: STRIPE and NONE hold across completed slots until `cs_idle` is high.
- R8: Outside striping, a slot pops one byte. `bus0_tx` and `bus1_tx` both carry `tx_head`, and only `rx_push0` may assert.
- R9: In STRIPE with `two_bus` high, a slot pops two bytes. `bus0_tx`=`tx_head` and `bus1_tx`=`tx_next`. Both received bytes are pushed, bus 0 first.
- R10: With `tx_avail`=0, the slot pops nothing, drives no bus and raises `tx_underflow`. In two-bus STRIPE with `tx_avail`=1, bus 0 alone pops and transfers, and `tx_underflow` is raised. In both cases the slot does not complete and the state is unchanged.
- R11: Each push needs a free RX entry, taken in order: bus 0, then bus 1. A push that finds no room is dropped and `rx_overflow` is raised.
- R12: With `two_bus` low, `bus1_active` and `rx_push1` stay low and at most one byte pops, in every state. The state still steps as in R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | A byte slot is processed this cycle |
| two_bus | input | 1 | Effective bus count is two |
| cs_idle | input | 1 | No chip select is active |
| tx_avail | input | 2 | TX FIFO fill level, clamped to 2 |
| rx_room | input | 2 | RX FIFO free entries, clamped to 2 |
| tx_head | input | 8 | Byte at the TX FIFO head |
| tx_next | input | 8 | Byte behind the TX FIFO head |
| bus0_tx | output | 8 | Byte sent on bus 0 |
| bus1_tx | output | 8 | Byte sent on bus 1 |
| bus0_active | output | 1 | Bus 0 transfers a byte this slot |
| bus1_active | output | 1 | Bus 1 transfers a byte this slot |
| tx_pops | output | 2 | Bytes popped from the TX FIFO |
| rx_push0 | output | 1 | Push bus 0's received byte |
| rx_push1 | output | 1 | Push bus 1's received byte |
| tx_underflow | output | 1 | A required pop found the TX FIFO empty |
| rx_overflow | output | 1 | A received byte was dropped for lack of room |
| snoop_kind | output | 2 | State: 0 CHECK, 1 COUNT, 2 NONE, 3 STRIPE |
| snoop_cnt | output | 3 | Remaining countdown in COUNT, else 0 |

## Verification
The bench covers the countdown boundary. Counting one slot too few or too many would start striping on the wrong byte and scramble the data phase on both devices. It covers a half-filled FIFO during striping: a design that still completes the slot would advance the state, or pop a byte that does not exist for bus 1. It makes `cs_idle` coincide with a slot, which a design with the wrong priority would lose. It runs the whole sequence again with one bus, where any bus 1 activity or double pop would corrupt the FIFOs. Unknown opcodes and every listed opcode are swept so that each decode class and the NONE hold are seen.

// File: rtl/flash_snoop_pkg.sv
package flash_snoop_pkg;
  parameter int BYTE_W = 8;
  parameter int LVL_W  = 2;
  parameter int CNT_W  = 3;

  typedef enum logic [1:0] {
    SN_CHECK  = 2'd0,
    SN_COUNT  = 2'd1,
    SN_NONE   = 2'd2,
    SN_STRIPE = 2'd3
  } snoop_kind_e;
endpackage

// File: rtl/flash_snoop_decode.sv
module flash_snoop_decode
  import flash_snoop_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output logic              known,
  output logic [CNT_W-1:0]  load_cnt
);
  // Address plus dummy byte counts per instruction class
  localparam logic [CNT_W-1:0] ADDR_ONLY  = CNT_W'(3);
  localparam logic [CNT_W-1:0] ADDR_DUMMY = CNT_W'(4);
  localparam logic [CNT_W-1:0] ADDR_QUAD  = CNT_W'(6);

  always_comb begin
    known    = 1'b1;
    load_cnt = '0;
    case (opcode)
      8'h03, 8'h02, 8'hA2, 8'h32: load_cnt = ADDR_ONLY;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: load_cnt = ADDR_DUMMY;
      8'hEB:                      load_cnt = ADDR_QUAD;
      default:                    known    = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_snoop_fsm.sv
module flash_snoop_fsm
  import flash_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              slot_done,
  input  logic [BYTE_W-1:0] opcode,
  output snoop_kind_e       kind,
  output logic [CNT_W-1:0]  cnt
);
  snoop_kind_e      kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             known;
  logic [CNT_W-1:0] load_cnt;
  logic             upd_en;

  flash_snoop_decode u_dec (
    .opcode   (opcode),
    .known    (known),
    .load_cnt (load_cnt)
  );

  assign upd_en = cs_idle | slot_done;

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    if (cs_idle) begin
      kind_d = SN_CHECK;
      cnt_d  = '0;
    end else if (slot_done) begin
      case (kind_q)
        SN_CHECK: begin
          if (known) begin
            kind_d = SN_COUNT;
            cnt_d  = load_cnt;
          end else begin
            kind_d = SN_NONE;
            cnt_d  = '0;
          end
        end
        SN_COUNT: begin
          if (cnt_q == CNT_W'(1)) begin
            kind_d = SN_STRIPE;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SN_CHECK;
      cnt_q  <= '0;
    end else if (upd_en) begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
    end
  end

  assign kind = kind_q;
  assign cnt  = cnt_q;

  // R2
  idle_to_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (kind == SN_CHECK && cnt == '0));

  // R7
  stripe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SN_STRIPE && !cs_idle) |=> kind == SN_STRIPE);

  // R7
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SN_NONE && !cs_idle) |=> kind == SN_NONE);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SN_COUNT && cnt > CNT_W'(1) && slot_done && !cs_idle)
      |=> (kind == SN_COUNT && cnt == $past(cnt) - CNT_W'(1)));

  // R10
  no_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_done && !cs_idle) |=> ($stable(kind) && $stable(cnt)));
endmodule

// File: rtl/flash_snoop_lanes.sv
module flash_snoop_lanes
  import flash_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  snoop_kind_e       kind,
  input  logic              slot_vld,
  input  logic              two_bus,
  input  logic [LVL_W-1:0]  tx_avail,
  input  logic [LVL_W-1:0]  rx_room,
  input  logic [BYTE_W-1:0] tx_head,
  input  logic [BYTE_W-1:0] tx_next,
  output logic [BYTE_W-1:0] bus0_tx,
  output logic [BYTE_W-1:0] bus1_tx,
  output logic              bus0_active,
  output logic              bus1_active,
  output logic [LVL_W-1:0]  tx_pops,
  output logic              rx_push0,
  output logic              rx_push1,
  output logic              tx_underflow,
  output logic              rx_overflow
);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);
  localparam logic [LVL_W-1:0] TWO = LVL_W'(2);

  logic stripe;
  logic pair_ok;

  assign stripe  = (kind == SN_STRIPE) & two_bus;
  assign pair_ok = (tx_avail >= TWO);
  assign bus0_tx = tx_head;
  assign bus1_tx = stripe ? tx_next : tx_head;

  always_comb begin
    bus0_active  = 1'b0;
    bus1_active  = 1'b0;
    tx_pops      = '0;
    rx_push0     = 1'b0;
    rx_push1     = 1'b0;
    tx_underflow = 1'b0;
    rx_overflow  = 1'b0;
    if (slot_vld) begin
      if (tx_avail == '0) begin
        tx_underflow = 1'b1;
      end else begin
        bus0_active = 1'b1;
        tx_pops     = ONE;
        rx_push0    = (rx_room != '0);
        rx_overflow = (rx_room == '0);
        if (stripe) begin
          if (pair_ok) begin
            bus1_active = 1'b1;
            tx_pops     = TWO;
            rx_push1    = (rx_room >= TWO);
            rx_overflow = (rx_room < TWO);
          end else begin
            tx_underflow = 1'b1;
          end
        end else begin
          bus1_active = two_bus;
        end
      end
    end
  end

  // R12
  single_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !two_bus |-> (!bus1_active && !rx_push1 && tx_pops <= ONE));

  // R11
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LVL_W'($countones({rx_push0, rx_push1})) <= rx_room);

  // R10
  empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && tx_avail == '0) |-> (tx_pops == '0 && tx_underflow && !bus0_active));

  // R8
  dup_one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != SN_STRIPE) |-> (tx_pops <= ONE && !rx_push1));
endmodule

// File: rtl/flash_snoop_top.sv
module flash_snoop_top
  import flash_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_vld,
  input  logic              two_bus,
  input  logic              cs_idle,
  input  logic [LVL_W-1:0]  tx_avail,
  input  logic [LVL_W-1:0]  rx_room,
  input  logic [BYTE_W-1:0] tx_head,
  input  logic [BYTE_W-1:0] tx_next,
  output logic [BYTE_W-1:0] bus0_tx,
  output logic [BYTE_W-1:0] bus1_tx,
  output logic              bus0_active,
  output logic              bus1_active,
  output logic [LVL_W-1:0]  tx_pops,
  output logic              rx_push0,
  output logic              rx_push1,
  output logic              tx_underflow,
  output logic              rx_overflow,
  output logic [1:0]        snoop_kind,
  output logic [CNT_W-1:0]  snoop_cnt
);
  snoop_kind_e kind;
  logic        slot_done;

  flash_snoop_lanes u_lanes (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .slot_vld     (slot_vld),
    .two_bus      (two_bus),
    .tx_avail     (tx_avail),
    .rx_room      (rx_room),
    .tx_head      (tx_head),
    .tx_next      (tx_next),
    .bus0_tx      (bus0_tx),
    .bus1_tx      (bus1_tx),
    .bus0_active  (bus0_active),
    .bus1_active  (bus1_active),
    .tx_pops      (tx_pops),
    .rx_push0     (rx_push0),
    .rx_push1     (rx_push1),
    .tx_underflow (tx_underflow),
    .rx_overflow  (rx_overflow)
  );

  assign slot_done = slot_vld & ~tx_underflow;

  flash_snoop_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_idle   (cs_idle),
    .slot_done (slot_done),
    .opcode    (tx_head),
    .kind      (kind),
    .cnt       (snoop_cnt)
  );

  assign snoop_kind = kind;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (snoop_kind == 2'd0 && snoop_cnt == '0));
endmodule

// File: tb/flash_snoop_top_test.sv
`timescale 1ns/100ps
module flash_snoop_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       slot_vld, two_bus, cs_idle;
  logic [1:0] tx_avail, rx_room;
  logic [7:0] tx_head, tx_next;
  logic [7:0] bus0_tx, bus1_tx;
  logic       bus0_active, bus1_active;
  logic [1:0] tx_pops;
  logic       rx_push0, rx_push1, tx_underflow, rx_overflow;
  logic [1:0] snoop_kind;
  logic [2:0] snoop_cnt;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  flash_snoop_top uut (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .two_bus(two_bus),
    .cs_idle(cs_idle), .tx_avail(tx_avail), .rx_room(rx_room),
    .tx_head(tx_head), .tx_next(tx_next), .bus0_tx(bus0_tx), .bus1_tx(bus1_tx),
    .bus0_active(bus0_active), .bus1_active(bus1_active), .tx_pops(tx_pops),
    .rx_push0(rx_push0), .rx_push1(rx_push1), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow), .snoop_kind(snoop_kind), .snoop_cnt(snoop_cnt)
  );

  typedef struct packed {
    logic       cs;
    logic       tb;
    logic [1:0] avail;
    logic [1:0] room;
    logic [7:0] head;
    logic [7:0] nxt;
    logic [1:0] e_pops;
    logic       e_p0;
    logic       e_p1;
    logic       e_uf;
    logic       e_of;
    logic       e_b1;
    logic [7:0] e_b1tx;
    logic [1:0] e_kind;
    logic [2:0] e_cnt;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    // R3 R8: read opcode, duplicated on both buses
    '{1'b0,1'b1,2'd2,2'd2,8'h03,8'h55,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h03,2'd1,3'd3},
    // R6 countdown
    '{1'b0,1'b1,2'd2,2'd2,8'hAA,8'h55,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'hAA,2'd1,3'd2},
    '{1'b0,1'b1,2'd2,2'd2,8'hBB,8'h55,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'hBB,2'd1,3'd1},
    '{1'b0,1'b1,2'd2,2'd2,8'hCC,8'h55,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'hCC,2'd3,3'd0},
    // R9 striping
    '{1'b0,1'b1,2'd2,2'd2,8'h11,8'h22,2'd2,1'b1,1'b1,1'b0,1'b0,1'b1,8'h22,2'd3,3'd0},
    // R10 half-filled FIFO while striping
    '{1'b0,1'b1,2'd1,2'd2,8'h33,8'h44,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,2'd3,3'd0},
    // R11 room for one only
    '{1'b0,1'b1,2'd2,2'd1,8'h35,8'h46,2'd2,1'b1,1'b0,1'b0,1'b1,1'b1,8'h46,2'd3,3'd0},
    // R11 no room
    '{1'b0,1'b1,2'd2,2'd0,8'h37,8'h48,2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,8'h48,2'd3,3'd0},
    // R2 idle together with a slot
    '{1'b1,1'b1,2'd2,2'd2,8'h0B,8'h66,2'd2,1'b1,1'b1,1'b0,1'b0,1'b1,8'h66,2'd0,3'd0},
    // R4
    '{1'b0,1'b1,2'd2,2'd2,8'h0B,8'h66,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h0B,2'd1,3'd4},
    // R10 empty FIFO in COUNT
    '{1'b0,1'b1,2'd0,2'd2,8'h77,8'h66,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,2'd1,3'd4},
    // R11 overflow outside striping still completes the slot
    '{1'b0,1'b1,2'd2,2'd0,8'h78,8'h66,2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h78,2'd1,3'd3},
    // R2
    '{1'b1,1'b1,2'd2,2'd2,8'h00,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,2'd0,3'd0},
    // R5 quad opcode
    '{1'b0,1'b1,2'd2,2'd2,8'hEB,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'hEB,2'd1,3'd6},
    '{1'b1,1'b1,2'd2,2'd2,8'h00,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,2'd0,3'd0},
    // R5 unknown opcode
    '{1'b0,1'b1,2'd2,2'd2,8'h9F,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h9F,2'd2,3'd0},
    // R7 NONE holds, no decode
    '{1'b0,1'b1,2'd2,2'd2,8'h03,8'h12,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h03,2'd2,3'd0},
    '{1'b1,1'b1,2'd2,2'd2,8'h00,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,2'd0,3'd0},
    // R12 single bus
    '{1'b0,1'b0,2'd2,2'd2,8'h6B,8'h01,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,3'd4},
    '{1'b0,1'b0,2'd2,2'd2,8'h01,8'h02,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,3'd3},
    '{1'b0,1'b0,2'd2,2'd2,8'h01,8'h02,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,3'd2},
    '{1'b0,1'b0,2'd2,2'd2,8'h01,8'h02,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd1,3'd1},
    '{1'b0,1'b0,2'd2,2'd2,8'h01,8'h02,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd3,3'd0},
    '{1'b0,1'b0,2'd2,2'd2,8'h5A,8'hA5,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd3,3'd0},
    '{1'b1,1'b0,2'd2,2'd2,8'h00,8'h00,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,2'd0,3'd0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic cs, input logic tb, input logic [1:0] av,
                       input logic [1:0] rm, input logic [7:0] hd, input logic [7:0] nx);
    @(negedge clk);
    slot_vld = 1'b1; cs_idle = cs; two_bus = tb;
    tx_avail = av; rx_room = rm; tx_head = hd; tx_next = nx;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    slot_vld = 1'b0; cs_idle = 1'b1;
    @(posedge clk); #1;
    cs_idle = 1'b0;
  endtask

  task automatic opcode_case(input logic [7:0] op, input logic [1:0] ek, input logic [2:0] ec,
                             input string req);
    idle_cycle();
    drive(1'b0, 1'b1, 2'd2, 2'd2, op, 8'h00);
    @(posedge clk); #1;
    check(req, "opcode kind", snoop_kind, ek);
    check(req, "opcode cnt", snoop_cnt, ec);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_vld = 1'b0; two_bus = 1'b1; cs_idle = 1'b0;
    tx_avail = '0; rx_room = '0; tx_head = '0; tx_next = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset kind", snoop_kind, 0);
    check("R1", "reset cnt", snoop_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cs, VECS[i].tb, VECS[i].avail, VECS[i].room, VECS[i].head, VECS[i].nxt);
      #1;
      check("R8/R9/R10/R11/R12", $sformatf("v%0d pops", i), tx_pops, VECS[i].e_pops);
      check("R8/R9/R11", $sformatf("v%0d push0", i), rx_push0, VECS[i].e_p0);
      check("R9/R12", $sformatf("v%0d push1", i), rx_push1, VECS[i].e_p1);
      check("R10", $sformatf("v%0d underflow", i), tx_underflow, VECS[i].e_uf);
      check("R11", $sformatf("v%0d overflow", i), rx_overflow, VECS[i].e_of);
      check("R12", $sformatf("v%0d bus1_active", i), bus1_active, VECS[i].e_b1);
      check("R10", $sformatf("v%0d bus0_active", i), bus0_active, VECS[i].e_pops != 2'd0);
      check("R8/R9", $sformatf("v%0d bus0_tx", i), bus0_tx, VECS[i].head);
      if (VECS[i].e_b1)
        check("R8/R9", $sformatf("v%0d bus1_tx", i), bus1_tx, VECS[i].e_b1tx);
      @(posedge clk); #1;
      check("R3/R4/R5/R6/R7", $sformatf("v%0d kind", i), snoop_kind, VECS[i].e_kind);
      check("R6", $sformatf("v%0d cnt", i), snoop_cnt, VECS[i].e_cnt);
    end

    // R3, R4, R5: remaining opcodes of each class
    opcode_case(8'h02, 2'd1, 3'd3, "R3");
    opcode_case(8'hA2, 2'd1, 3'd3, "R3");
    opcode_case(8'h32, 2'd1, 3'd3, "R3");
    opcode_case(8'h3B, 2'd1, 3'd4, "R4");
    opcode_case(8'h6B, 2'd1, 3'd4, "R4");
    opcode_case(8'hBB, 2'd1, 3'd4, "R4");
    opcode_case(8'hEC, 2'd2, 3'd0, "R5");
    opcode_case(8'h00, 2'd2, 3'd0, "R5");

    // R6: no slot, no change in COUNT
    opcode_case(8'hEB, 2'd1, 3'd6, "R5");
    @(negedge clk);
    slot_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R6", "no-slot kind", snoop_kind, 1);
    check("R6", "no-slot cnt", snoop_cnt, 6);
    check("R6", "no-slot pops", tx_pops, 0);

    // R1: reset in the middle of a countdown
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mid reset kind", snoop_kind, 0);
    check("R1", "mid reset cnt", snoop_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: empty FIFO in CHECK does not decode the stale head
    drive(1'b0, 1'b1, 2'd0, 2'd2, 8'h03, 8'h00);
    @(posedge clk); #1;
    check("R10", "empty check kind", snoop_kind, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule